// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Walker

This block runs a scatter-gather transfer from a table of region descriptors in host memory. A one-cycle start pulse supplies the table's address, the command's total byte budget and the transfer direction. The walker then reads one 8-byte descriptor at a time through a simple request/response memory port. It splits the region that descriptor names into data bursts and moves on to the next table slot. Each descriptor is a 64-bit little-endian word. Bits [31:0] hold the region address, with bit 0 treated as zero. Bits [47:32] hold the byte count, with bit 0 treated as zero, and a count of zero stands for 0x10000 bytes. Bit 63, the top bit of the upper halfword, marks the final descriptor.

The memory port carries one request at a time. A request is held until `mem_req_ready` is high, and each accepted request is answered by one `mem_rsp_valid` cycle. For a descriptor fetch, that response carries the descriptor word. For a data burst, the response marks the burst as complete. The walk ends with a one-cycle `done` pulse. A one-cycle `abort` input stops it early and gives a one-cycle `aborted` pulse instead.

The controller has five states. ST_IDLE waits for start. ST_DESC_REQ presents the descriptor fetch, and ST_DESC_WAIT waits for the descriptor word. ST_BURST_REQ presents a data burst, and ST_BURST_WAIT waits for that burst to complete. Its transitions are:
- start: ST_IDLE to ST_DESC_REQ, for a non-zero budget.
- fetch accept: ST_DESC_REQ to ST_DESC_WAIT.
- descriptor arrival: ST_DESC_WAIT to ST_BURST_REQ.
- burst accept: ST_BURST_REQ to ST_BURST_WAIT.
- burst completion: ST_BURST_WAIT back to ST_BURST_REQ while bytes remain in the region.
- region end: from ST_BURST_WAIT, or from ST_BURST_REQ for an empty region, to ST_DESC_REQ, or to ST_IDLE after a final descriptor.
- budget exhaustion: any active state to ST_IDLE when the byte budget reaches zero.
- abort: any active state to ST_IDLE.

Top module: `sgdma_walker`

## Requirements
- R1: After reset, and whenever the walker is idle, `busy`, `done` and `aborted` are low and no memory request is presented.
- R2: Descriptor fetches read 8 bytes (`mem_req_len` = 8, `mem_req_desc` = 1) at the table address plus 8 times the number of descriptors already fetched.
- R3: The first burst of a region starts at the descriptor's bits [31:0] with bit 0 cleared, and later bursts follow at consecutive addresses.
- R4: A region's length is the descriptor's bits [47:32] with bit 0 cleared, or 0x10000 bytes when those bits are zero; a region of length zero issues no burst.
- R5: Each data burst has a length from 1 to BURST_BYTES (default 256) and takes the smallest of BURST_BYTES, the bytes left in the region and the bytes left in the budget.
- R6: A descriptor with bit 63 set is the last one: after its region completes, `done` pulses for one cycle and no further fetch is made.
- R7: The byte budget is limited to 0x20000. When the budget runs out, the final burst is trimmed to fit, `done` pulses, and no further descriptor is fetched even without bit 63.
- R8: An abort during a walk returns the walker to idle, pulses `aborted` for one cycle, gives no `done` and issues no further requests. An abort while idle has no effect.
- R9: `mem_req_wr` equals the latched direction flag for data bursts (1 = write to memory) and is 0 for descriptor fetches.
- R10: A start pulse during a walk is ignored. A start with a zero budget pulses `done` without any request.
- R11: A request that is not accepted stays presented with unchanged address, length and kind until it is accepted or the walk is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, honoured only when idle |
| table_base | input | ADDR_W | Address of the first descriptor |
| cmd_bytes | input | 18 | Byte budget of the command |
| to_mem | input | 1 | Direction: 1 writes data to memory, 0 reads it |
| abort | input | 1 | Abort request |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_len | output | 17 | Request length in bytes |
| mem_req_desc | output | 1 | Request is a descriptor fetch |
| mem_req_wr | output | 1 | Request writes to memory |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_data | input | 64 | Descriptor word carried by a fetch response |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| aborted | output | 1 | One-cycle pulse on an aborted walk |

## Verification
The walker is run over tables that separate each way a walk can end:
- a final descriptor after one or two regions;
- a budget that runs out part way through a region;
- a budget over the 0x20000 limit, which must be clamped;
- an odd budget, which gives an odd final burst.

The descriptor patterns are chosen to tell the decode rules apart. They include an odd address and an odd count, a zero count that must become 64 KiB, a count of one that must produce an empty region, and filler entries behind each last slot that show up as an extra fetch if a walk overruns. Both directions are run, with the memory always ready and with it alternating ready. The alternating case shows that held requests keep their address and length. Directed runs cover an abort mid-walk, an abort while idle, a repeated start during a walk and a zero budget.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;
    localparam int DESC_W      = 64;
    localparam int DESC_ADDR_W = 32;
    localparam int DESC_BYTES  = DESC_W / 8;
    localparam int REGION_W    = 17;
    localparam int CMD_W       = 18;
    localparam logic [REGION_W-1:0] REGION_MAX = 17'h10000;
    localparam logic [CMD_W-1:0]    CMD_MAX    = 18'h20000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_BURST_REQ,
        ST_BURST_WAIT
    } sg_state_e;

    typedef struct packed {
        logic [DESC_ADDR_W-1:0] addr;
        logic [REGION_W-1:0]    len;
        logic                   last;
    } sg_region_t;
endpackage

// File: rtl/sgdma_desc_decode.sv
`timescale 1ns/1ps
module sgdma_desc_decode
    import sgdma_pkg::*;
(
    input  logic [DESC_W-1:0] word,
    output sg_region_t        region
);
    logic [15:0] raw_count;
    logic        unused_desc_bits;

    assign raw_count = word[47:32];
    assign unused_desc_bits = ^{word[62:48], word[0], raw_count[0]};

    always_comb begin
        region.addr = {word[DESC_ADDR_W-1:1], 1'b0};
        region.len  = (raw_count == 16'h0) ? REGION_MAX
                                           : {1'b0, raw_count[15:1], 1'b0};
        region.last = word[63];
    end
endmodule

// File: rtl/sgdma_burst_sizer.sv
`timescale 1ns/1ps
module sgdma_burst_sizer
    import sgdma_pkg::*;
#(
    parameter int BURST_BYTES = 256
) (
    input  logic [REGION_W-1:0] region_left,
    input  logic [CMD_W-1:0]    cmd_left,
    output logic [REGION_W-1:0] burst_len
);
    localparam logic [CMD_W-1:0] CAP = CMD_W'(BURST_BYTES);

    logic [CMD_W-1:0] region_wide;
    logic [CMD_W-1:0] capped;
    logic [CMD_W-1:0] pick;
    logic             unused_top;

    assign region_wide = {1'b0, region_left};

    generate
        if (BURST_BYTES >= 65536) begin : g_no_cap
            assign capped = region_wide;
        end else begin : g_cap
            assign capped = (region_wide < CAP) ? region_wide : CAP;
        end
    endgenerate

    assign pick       = (capped < cmd_left) ? capped : cmd_left;
    assign burst_len  = pick[REGION_W-1:0];
    assign unused_top = pick[CMD_W-1];
endmodule

// File: rtl/sgdma_walker.sv
`timescale 1ns/1ps
module sgdma_walker
    import sgdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_BYTES = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   table_base,
    input  logic [CMD_W-1:0]    cmd_bytes,
    input  logic                to_mem,
    input  logic                abort,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [REGION_W-1:0] mem_req_len,
    output logic                mem_req_desc,
    output logic                mem_req_wr,
    input  logic                mem_rsp_valid,
    input  logic [DESC_W-1:0]   mem_rsp_data,
    output logic                busy,
    output logic                done,
    output logic                aborted
);
    localparam logic [ADDR_W-1:0]   DESC_STEP = ADDR_W'(DESC_BYTES);
    localparam logic [REGION_W-1:0] DESC_LEN  = REGION_W'(DESC_BYTES);

    sg_state_e            st, st_n;
    logic [ADDR_W-1:0]    desc_addr;
    logic [ADDR_W-1:0]    cur_addr;
    logic [REGION_W-1:0]  region_left;
    logic [CMD_W-1:0]     cmd_left;
    logic                 last_q;
    logic                 dir_q;
    logic                 done_q;
    logic                 abort_q;

    sg_region_t           region;
    logic [REGION_W-1:0]  burst_len;
    logic [CMD_W-1:0]     cmd_clamped;
    logic [CMD_W-1:0]     cmd_after;
    logic [REGION_W-1:0]  region_after;
    logic                 active;
    logic                 finish_ok;

    sgdma_desc_decode u_decode (
        .word   (mem_rsp_data),
        .region (region)
    );

    sgdma_burst_sizer #(.BURST_BYTES(BURST_BYTES)) u_sizer (
        .region_left (region_left),
        .cmd_left    (cmd_left),
        .burst_len   (burst_len)
    );

    assign cmd_clamped  = (cmd_bytes > CMD_MAX) ? CMD_MAX : cmd_bytes;
    assign cmd_after    = cmd_left - CMD_W'(burst_len);
    assign region_after = region_left - burst_len;
    assign active       = (st != ST_IDLE);

    // next-state decision
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: begin
                if (start && cmd_clamped != '0) st_n = ST_DESC_REQ;
            end
            ST_DESC_REQ: begin
                if (mem_req_ready) st_n = ST_DESC_WAIT;
            end
            ST_DESC_WAIT: begin
                if (mem_rsp_valid) st_n = ST_BURST_REQ;
            end
            ST_BURST_REQ: begin
                if (burst_len == '0)    st_n = last_q ? ST_IDLE : ST_DESC_REQ;
                else if (mem_req_ready) st_n = ST_BURST_WAIT;
            end
            ST_BURST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (cmd_after == '0)           st_n = ST_IDLE;
                    else if (region_after == '0)   st_n = last_q ? ST_IDLE : ST_DESC_REQ;
                    else                           st_n = ST_BURST_REQ;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (abort && active) st_n = ST_IDLE;
    end

    assign finish_ok = (active && st_n == ST_IDLE && !abort) ||
                       (!active && start && cmd_clamped == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_addr   <= '0;
            cur_addr    <= '0;
            region_left <= '0;
            cmd_left    <= '0;
            last_q      <= 1'b0;
            dir_q       <= 1'b0;
            done_q      <= 1'b0;
            abort_q     <= 1'b0;
        end else begin
            done_q  <= finish_ok;
            abort_q <= abort && active;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        desc_addr <= table_base;
                        cmd_left  <= cmd_clamped;
                        dir_q     <= to_mem;
                    end
                end
                ST_DESC_WAIT: begin
                    if (mem_rsp_valid) begin
                        cur_addr    <= region.addr[ADDR_W-1:0];
                        region_left <= region.len;
                        last_q      <= region.last;
                        desc_addr   <= desc_addr + DESC_STEP;
                    end
                end
                ST_BURST_WAIT: begin
                    if (mem_rsp_valid) begin
                        cur_addr    <= cur_addr + ADDR_W'(burst_len);
                        region_left <= region_after;
                        cmd_left    <= cmd_after;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req_desc  = (st == ST_DESC_REQ);
        mem_req_valid = !abort && (mem_req_desc ||
                        (st == ST_BURST_REQ && burst_len != '0));
        mem_req_addr  = mem_req_desc ? desc_addr : cur_addr;
        mem_req_len   = mem_req_desc ? DESC_LEN : burst_len;
        mem_req_wr    = (st == ST_BURST_REQ) && dir_q;
        busy          = active;
        done          = done_q;
        aborted       = abort_q;
    end
endmodule

// File: rtl/sgdma_walker_chk.sv
`timescale 1ns/1ps
module sgdma_walker_chk
    import sgdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_BYTES = 256
) (
    input logic                clk,
    input logic                rst_n,
    input logic                abort,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic [ADDR_W-1:0]   mem_req_addr,
    input logic [REGION_W-1:0] mem_req_len,
    input logic                mem_req_desc,
    input logic                mem_req_wr,
    input logic                busy,
    input logic                done,
    input logic                aborted
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid); // R1

    AST_DESC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_desc) |-> (mem_req_len == REGION_W'(DESC_BYTES) && !mem_req_wr)); // R2

    AST_DATA_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_desc) |-> !mem_req_addr[0]); // R3

    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_desc) |->
        (mem_req_len != '0 && mem_req_len <= REGION_W'(BURST_BYTES))); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && aborted)); // R8

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> !busy); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !abort) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len) &&
         $stable(mem_req_desc))); // R11
endmodule

bind sgdma_walker sgdma_walker_chk #(
    .ADDR_W      (ADDR_W),
    .BURST_BYTES (BURST_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort         (abort),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_len   (mem_req_len),
    .mem_req_desc  (mem_req_desc),
    .mem_req_wr    (mem_req_wr),
    .busy          (busy),
    .done          (done),
    .aborted       (aborted)
);

// File: tb/sgdma_walker_tb.sv
`timescale 1ns/1ps
module sgdma_walker_tb;
    localparam int  BURST = 256;
    localparam int  LOGN  = 1024;
    localparam logic [63:0] FILL = 64'h8000_0040_0000_F000;

    typedef struct packed {
        logic [31:0] tbase;
        logic [17:0] cmd;
        logic        dir;
        logic        stall;
        logic [63:0] d0;
        logic [63:0] d1;
        logic [63:0] d2;
        logic [15:0] e_fetch;
        logic [15:0] e_burst;
        logic [31:0] e_bytes;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 18'h20000, 1'b0, 1'b0, 64'h8000_0200_0000_2000, FILL, FILL, 16'd1, 16'd2, 32'h200},
        '{32'h1100, 18'h20000, 1'b1, 1'b1, 64'h0000_0101_0000_3001, 64'h8000_0100_0000_4000, FILL, 16'd2, 16'd2, 32'h200},
        '{32'h1200, 18'h20000, 1'b0, 1'b0, 64'h8000_0000_0001_0000, FILL, FILL, 16'd1, 16'd256, 32'h10000},
        '{32'h1300, 18'h00400, 1'b1, 1'b0, 64'h0000_0300_0000_5000, 64'h0000_0300_0000_6000, 64'h8000_0300_0000_7000, 16'd2, 16'd4, 32'h400},
        '{32'h1400, 18'h3FFFF, 1'b0, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0002_0000, 64'h8000_0100_0004_0000, 16'd2, 16'd512, 32'h20000},
        '{32'h1500, 18'h20000, 1'b1, 1'b1, 64'h0000_0001_0000_8000, 64'h8000_0080_0000_9000, FILL, 16'd2, 16'd1, 32'h80},
        '{32'h1600, 18'h00033, 1'b0, 1'b0, 64'h8000_0100_0000_A000, FILL, FILL, 16'd1, 16'd1, 32'h33}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] table_base = '0;
    logic [17:0] cmd_bytes = '0;
    logic        to_mem = 1'b0;
    logic        abort = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [16:0] mem_req_len;
    logic        mem_req_desc;
    logic        mem_req_wr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        busy;
    logic        done;
    logic        aborted;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sgdma_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
        .cmd_bytes(cmd_bytes), .to_mem(to_mem), .abort(abort),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
        .mem_req_desc(mem_req_desc), .mem_req_wr(mem_req_wr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .done(done), .aborted(aborted)
    );

    // memory model state
    logic [31:0] cur_tbase = '0;
    logic [63:0] cur_d [3];
    logic        stall = 1'b0;
    int          cyc = 0;
    logic        pend = 1'b0;
    logic        pend_desc = 1'b0;
    logic [31:0] pend_addr = '0;
    int          done_cnt = 0;
    int          abort_cnt = 0;

    logic [31:0] log_addr [LOGN];
    logic [16:0] log_len  [LOGN];
    logic        log_desc [LOGN];
    logic        log_wr   [LOGN];
    int          log_n = 0;

    logic [31:0] exp_addr [LOGN];
    logic [16:0] exp_len  [LOGN];
    logic        exp_desc [LOGN];
    logic        exp_wr   [LOGN];
    int          exp_n = 0;

    function automatic logic [63:0] desc_word(input logic [31:0] a);
        logic [31:0] idx;
        idx = (a - cur_tbase) >> 3;
        if (idx < 3) return cur_d[idx];
        return FILL;
    endfunction

    // memory responder and monitor, acting away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pend_desc ? desc_word(pend_addr) : 64'h0;
            pend = 1'b0;
        end
        mem_req_ready = stall ? cyc[0] : 1'b1;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (log_n < LOGN) begin
                log_addr[log_n] = mem_req_addr;
                log_len[log_n]  = mem_req_len;
                log_desc[log_n] = mem_req_desc;
                log_wr[log_n]   = mem_req_wr;
            end
            log_n     = log_n + 1;
            pend      = 1'b1;
            pend_desc = mem_req_desc;
            pend_addr = mem_req_addr;
        end
        if (done)    done_cnt  = done_cnt + 1;
        if (aborted) abort_cnt = abort_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input logic [31:0] a, input logic [16:0] l,
                            input logic d, input logic w);
        if (exp_n < LOGN) begin
            exp_addr[exp_n] = a; exp_len[exp_n] = l;
            exp_desc[exp_n] = d; exp_wr[exp_n]  = w;
        end
        exp_n++;
    endtask

    // expected request list derived from the requirements
    task automatic build_exp(input logic [31:0] tb_, input logic [17:0] cmd, input logic dir);
        longint left, r, b, a, da;
        logic [63:0] w;
        logic eot;
        exp_n = 0;
        left = (cmd > 18'h20000) ? 64'h20000 : longint'(cmd);
        da = tb_;
        while (left > 0) begin
            push_exp(da[31:0], 17'd8, 1'b1, 1'b0);
            w = desc_word(da[31:0]);
            da = da + 8;
            a = longint'(w[31:0]) & ~64'h1;
            r = (w[47:32] == 16'h0) ? 64'h10000 : (longint'(w[47:32]) & ~64'h1);
            eot = w[63];
            while (r > 0 && left > 0) begin
                b = BURST;
                if (r < b) b = r;
                if (left < b) b = left;
                push_exp(a[31:0], b[16:0], 1'b0, dir);
                a = a + b; r = r - b; left = left - b;
            end
            if (eot) break;
        end
    endtask

    task automatic clear_obs();
        log_n = 0; done_cnt = 0; abort_cnt = 0;
    endtask

    task automatic launch(input logic [31:0] tb_, input logic [17:0] cmd, input logic dir);
        @(negedge clk);
        table_base = tb_; cmd_bytes = cmd; to_mem = dir; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        int t = 0;
        while (done_cnt == 0 && abort_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic check_seq(input string req);
        int bad = -1;
        if (log_n == exp_n) begin
            for (int i = 0; i < log_n && i < LOGN; i++) begin
                if (bad < 0 && (log_addr[i] != exp_addr[i] || log_len[i] != exp_len[i] ||
                    log_desc[i] != exp_desc[i] || log_wr[i] != exp_wr[i])) bad = i;
            end
        end
        if (log_n != exp_n)
            check(1'b0, req, "request count", log_n, exp_n);
        else if (bad >= 0)
            check(1'b0, req, $sformatf("request %0d addr", bad), log_addr[bad], exp_addr[bad]);
        else
            check(1'b1, req, "sequence", 0, 0);
    endtask

    initial begin
        int nf, nb;
        longint by;

        cur_d[0] = FILL; cur_d[1] = FILL; cur_d[2] = FILL;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!busy && !mem_req_valid && !done && !aborted, "R1", "reset outputs",
              {busy, mem_req_valid, done, aborted}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !mem_req_valid, "R1", "idle after reset", {busy, mem_req_valid}, 0);

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            cur_tbase = VECS[v].tbase;
            cur_d[0] = VECS[v].d0; cur_d[1] = VECS[v].d1; cur_d[2] = VECS[v].d2;
            stall = VECS[v].stall;
            clear_obs();
            build_exp(VECS[v].tbase, VECS[v].cmd, VECS[v].dir);
            launch(VECS[v].tbase, VECS[v].cmd, VECS[v].dir);
            wait_end();
            nf = 0; nb = 0; by = 0;
            for (int i = 0; i < log_n && i < LOGN; i++) begin
                if (log_desc[i]) nf++;
                else begin nb++; by += log_len[i]; end
            end
            check(done_cnt == 1 && abort_cnt == 0, "R6/R7", $sformatf("vec %0d done pulses", v), done_cnt, 1);
            check(nf == VECS[v].e_fetch, "R2", $sformatf("vec %0d fetches", v), nf, VECS[v].e_fetch);
            check(nb == VECS[v].e_burst, "R5", $sformatf("vec %0d bursts", v), nb, VECS[v].e_burst);
            check(by == VECS[v].e_bytes, "R4 R7", $sformatf("vec %0d bytes", v), by, VECS[v].e_bytes);
            check_seq($sformatf("R3 R9 R11 vec %0d", v));
        end
        stall = 1'b0;

        // R8: abort mid-walk
        begin
            int frozen;
            cur_tbase = 32'h2000; cur_d[0] = 64'h8000_0000_0001_0000; cur_d[1] = FILL; cur_d[2] = FILL;
            clear_obs();
            launch(32'h2000, 18'h20000, 1'b1);
            repeat (40) @(negedge clk);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            repeat (3) @(negedge clk);
            check(abort_cnt == 1, "R8", "aborted pulses", abort_cnt, 1);
            check(done_cnt == 0, "R8", "done after abort", done_cnt, 0);
            check(!busy, "R8", "busy after abort", busy, 0);
            frozen = log_n;
            repeat (20) @(negedge clk);
            check(log_n == frozen, "R8", "requests after abort", log_n, frozen);
            // abort while idle
            abort_cnt = 0;
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            repeat (3) @(negedge clk);
            check(abort_cnt == 0 && !busy && log_n == frozen, "R8", "idle abort effect",
                  abort_cnt, 0);
        end

        // R10: start while busy ignored
        cur_tbase = 32'h1300;
        cur_d[0] = VECS[3].d0; cur_d[1] = VECS[3].d1; cur_d[2] = VECS[3].d2;
        stall = 1'b1;
        clear_obs();
        build_exp(32'h1300, 18'h00400, 1'b0);
        launch(32'h1300, 18'h00400, 1'b0);
        repeat (5) @(negedge clk);
        table_base = 32'h9990; cmd_bytes = 18'h10; to_mem = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        check(done_cnt == 1, "R10", "done with second start", done_cnt, 1);
        check_seq("R10 restart ignored");
        stall = 1'b0;

        // R10: zero budget
        clear_obs();
        launch(32'h1000, 18'h0, 1'b0);
        repeat (5) @(negedge clk);
        check(done_cnt == 1, "R10", "zero budget done", done_cnt, 1);
        check(log_n == 0 && !busy, "R10", "zero budget requests", log_n, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule